// File: doc/BRIEF.md
# RISC Instruction Field Decoder

This block takes one 32-bit instruction word from a three-format RISC instruction set, together with the address that word was fetched from. It turns the word into the control and operand information an execution stage needs. It pulls out the register indices, the immediates and both opcode fields. It classifies the instruction into an ALU operation, a memory access, a branch, a direct or register-indirect jump, or an exception request. It also computes the control-flow target and the link value from the fetch address.

Decoding is combinational. The result is captured in one output register stage, which loads only when the input is marked valid and otherwise holds its contents. The register file, execution, memory access and pipeline control are outside this block. The decoder only reports what an instruction asks for. Writes that would land in register zero are already removed from its write strobe.

Top module: `insn_field_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `outValid`, `regWrite`, `memRead`, `memWrite`, `isBranch`, `isJump`, `isJumpReg` and `excValid` are 0.
- R2: A word presented with `inValid` high shows its decode on the outputs after the next rising clock edge, with `outValid` high. In a cycle where `inValid` is low, `outValid` goes low and every other output keeps its previous value.
- R3: Bit fields are fixed. The main opcode is bits [5:0]. Register A is [31:27] and register B is [26:22]. The 16-bit immediate is [21:6]. In register-format words, register C is [21:17], the 5-bit shift/index field is [10:6] and the extended opcode is [16:11]. `srcA` carries register A and `srcB` carries register B.
- R4: Main opcode 0x3A selects the register format, whose operation comes from the extended opcode. Every other main opcode is decoded by itself. Register-format ALU results target register C, and immediate-format ALU, compare and load results target register B.
- R5: `immValue` holds the operand immediate with `useImm` set. It is sign-extended for add/multiply, for the signed compares and for load/store offsets. It is zero-extended for and/or/xor and the unsigned compares. The high-half logic forms place it in bits [31:16]. Shift-immediate and control-register index forms take the zero-extended 5-bit field.
- R6: Main opcodes 0x01 (jump) and 0x00 (call) set `isJump` with target {PC[31:28], bits[31:6], 2'b00}. A call also writes `linkValue` = PC+4 into register 31.
- R7: Main opcodes with low bits 3'b110 are branches (0x3E excepted). The target is PC+4 plus the sign-extended 16-bit immediate with its two low bits cleared. `brCond` equals main opcode bits [5:3]: 0 always, 1 signed >=, 2 signed <, 3 not equal, 4 equal, 5 unsigned >=, 6 unsigned <.
- R8: Loads are 0x03, 0x07, 0x0B, 0x0F and 0x17. Stores are 0x05, 0x0D and 0x15. `memSize` is 0 for byte, 1 for half and 2 for word. `memSigned` is set for 0x07 and 0x0F. Adding 0x20 gives the same access with `memIo` set.
- R9: A result whose destination index is 0 leaves `regWrite` low. A load aimed at register 0 still raises `memRead`.
- R10: Any unassigned main or extended opcode raises `excValid` with `excCause` 0 (illegal). In that case no register write, memory access, branch or jump is requested.
- R11: Extended opcode 0x2D gives `excCause` 1 (trap) and 0x34 gives 2 (break). Main 0x32 and 0x38 and extended 0x14 give 3 (unimplemented). All of these suppress side effects as in R10.
- R12: The cache-maintenance codes decode to no operation: main 0x13, 0x1B, 0x33 and 0x3B, and extended 0x04, 0x0C, 0x29 and 0x36. They raise no exception, write and memory strobes.
- R13: The register-indirect transfers set `isJumpReg` with `srcA` as the address source. Extended 0x0D uses register A, 0x05 uses register 31, 0x01 uses register 29 and 0x09 uses register 30. Extended 0x1D (indirect call) writes PC+4 to register 31. Extended 0x1C writes PC+4 to register C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Word and address are valid this cycle |
| insnWord | input | 32 | Instruction word |
| pcIn | input | 32 | Fetch address of the word |
| outValid | output | 1 | Outputs hold a decode captured last cycle |
| aluOp | output | 5 | ALU operation code (package enumeration) |
| useImm | output | 1 | Second operand is `immValue` |
| immValue | output | 32 | Extended immediate |
| srcA | output | 5 | First source register |
| srcB | output | 5 | Second source register / store data |
| destReg | output | 5 | Destination register |
| regWrite | output | 1 | Register write requested |
| memRead | output | 1 | Load access |
| memWrite | output | 1 | Store access |
| memSize | output | 2 | Access size: 0 byte, 1 half, 2 word |
| memSigned | output | 1 | Load result is sign-extended |
| memIo | output | 1 | Uncached I/O access |
| isBranch | output | 1 | PC-relative branch |
| brCond | output | 3 | Branch condition |
| isJump | output | 1 | Direct region jump |
| isJumpReg | output | 1 | Jump through `srcA` |
| linkSel | output | 1 | Write `linkValue` to `destReg` |
| linkValue | output | 32 | Fetch address plus 4 |
| target | output | 32 | Branch or jump target |
| excValid | output | 1 | Exception requested |
| excCause | output | 2 | 0 illegal, 1 trap, 2 break, 3 unimplemented |

## Verification
The hardest cases to reach from the ports are the sparse holes in the extended-opcode table and the register-zero corners. Fully random words almost never pick main opcode 0x3A, and they rarely pick a zero destination together with a load. The stimulus therefore forces the main opcode to 0x3A for half of the random words so the whole extended table is swept. It adds directed words for a load into register 0, a negative branch offset with its low immediate bits set, and jumps from an address with a non-zero top nibble.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int PRIM_W    = 6;
  localparam int ALU_W     = 5;
  localparam int IMM16_W   = 16;
  localparam int IMM26_W   = 26;
  localparam int SH_W      = 5;
  localparam int COND_W    = 3;
  localparam int REGION_W  = 4;
  localparam int IMM16_LSB = 6;
  localparam int SH_LSB    = 6;
  localparam int EXT_LSB   = 11;
  localparam int RC_LSB    = 17;
  localparam int RB_LSB    = 22;
  localparam int RA_LSB    = 27;

  localparam logic [PRIM_W-1:0]    R_FMT_OP    = 6'h3A;
  localparam logic [REG_IDX_W-1:0] LINK_REG    = 5'd31;
  localparam logic [REG_IDX_W-1:0] EXC_RET_REG = 5'd29;
  localparam logic [REG_IDX_W-1:0] BRK_RET_REG = 5'd30;

  typedef enum logic [ALU_W-1:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_MUL, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_ROL, ALU_ROR,
    ALU_CMPGE, ALU_CMPLT, ALU_CMPNE, ALU_CMPEQ, ALU_CMPGEU, ALU_CMPLTU,
    ALU_MULHUU, ALU_MULHSU, ALU_MULHSS, ALU_DIVU, ALU_DIV,
    ALU_CTLRD, ALU_CTLWR, ALU_EXCRET
  } aluOpE;

  typedef enum logic [2:0] {IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_HIGH, IMM_SHAMT} immKindE;
  typedef enum logic [1:0] {TGT_NONE, TGT_JUMP, TGT_BRANCH} tgtKindE;
  typedef enum logic [1:0] {DST_NONE, DST_B, DST_C, DST_LINK} dstSelE;
  typedef enum logic [1:0] {SRCA_FIELD, SRCA_EXC, SRCA_BRK, SRCA_RET} srcASelE;
  typedef enum logic [1:0] {EXC_ILLEGAL, EXC_TRAP, EXC_BREAK, EXC_UNIMPL} excCauseE;

  typedef struct packed {
    aluOpE             aluOp;
    immKindE           immKind;
    tgtKindE           tgtKind;
    dstSelE            dstSel;
    srcASelE           srcASel;
    logic              linkSel;
    logic              jumpReg;
    logic              memRead;
    logic              memWrite;
    logic [1:0]        memSize;
    logic              memSigned;
    logic              memIo;
    logic [COND_W-1:0] brCond;
    logic              excValid;
    excCauseE          excCause;
  } ctrlStrobesT;
endpackage

// File: rtl/insn_dec_ctrl.sv
module insn_dec_ctrl
  import insn_dec_pkg::*;
(
  input  logic [PRIM_W-1:0] primOp,
  input  logic [PRIM_W-1:0] extOp,
  output ctrlStrobesT       strobes
);

  function automatic aluOpE cmpAlu(input logic [2:0] idx);
    case (idx)
      3'd1:    return ALU_CMPGE;
      3'd2:    return ALU_CMPLT;
      3'd3:    return ALU_CMPNE;
      3'd4:    return ALU_CMPEQ;
      3'd5:    return ALU_CMPGEU;
      3'd6:    return ALU_CMPLTU;
      default: return ALU_NONE;
    endcase
  endfunction

  function automatic ctrlStrobesT rAlu(input aluOpE op, input immKindE kind);
    ctrlStrobesT s = '0;
    s.aluOp   = op;
    s.immKind = kind;
    s.dstSel  = DST_C;
    return s;
  endfunction

  function automatic ctrlStrobesT iAlu(input aluOpE op, input immKindE kind);
    ctrlStrobesT s = '0;
    s.aluOp   = op;
    s.immKind = kind;
    s.dstSel  = DST_B;
    return s;
  endfunction

  function automatic ctrlStrobesT excOf(input excCauseE cause);
    ctrlStrobesT s = '0;
    s.excValid = 1'b1;
    s.excCause = cause;
    return s;
  endfunction

  function automatic ctrlStrobesT viaReg(input srcASelE sel, input aluOpE op);
    ctrlStrobesT s = '0;
    s.jumpReg = 1'b1;
    s.srcASel = sel;
    s.aluOp   = op;
    return s;
  endfunction

  logic [2:0] grpLow;
  logic [2:0] grpHigh;
  logic [1:0] accSize;

  assign grpLow  = primOp[2:0];
  assign grpHigh = primOp[5:3];
  assign accSize = primOp[4:3];

  always_comb begin
    strobes = '0;
    if (primOp == R_FMT_OP) begin
      case (extOp)
        6'h01: strobes = viaReg(SRCA_EXC, ALU_EXCRET);
        6'h02: strobes = rAlu(ALU_ROL, IMM_SHAMT);
        6'h03: strobes = rAlu(ALU_ROL, IMM_NONE);
        6'h04, 6'h0C, 6'h29, 6'h36: strobes = '0;
        6'h05: strobes = viaReg(SRCA_RET, ALU_NONE);
        6'h06: strobes = rAlu(ALU_NOR, IMM_NONE);
        6'h07: strobes = rAlu(ALU_MULHUU, IMM_NONE);
        6'h08: strobes = rAlu(ALU_CMPGE, IMM_NONE);
        6'h09: strobes = viaReg(SRCA_BRK, ALU_EXCRET);
        6'h0B: strobes = rAlu(ALU_ROR, IMM_NONE);
        6'h0D: strobes = viaReg(SRCA_FIELD, ALU_NONE);
        6'h0E: strobes = rAlu(ALU_AND, IMM_NONE);
        6'h10: strobes = rAlu(ALU_CMPLT, IMM_NONE);
        6'h12: strobes = rAlu(ALU_SLL, IMM_SHAMT);
        6'h13: strobes = rAlu(ALU_SLL, IMM_NONE);
        6'h14: strobes = excOf(EXC_UNIMPL);
        6'h16: strobes = rAlu(ALU_OR, IMM_NONE);
        6'h17: strobes = rAlu(ALU_MULHSU, IMM_NONE);
        6'h18: strobes = rAlu(ALU_CMPNE, IMM_NONE);
        6'h1A: strobes = rAlu(ALU_SRL, IMM_SHAMT);
        6'h1B: strobes = rAlu(ALU_SRL, IMM_NONE);
        6'h1C: begin
          strobes = rAlu(ALU_NONE, IMM_NONE);
          strobes.linkSel = 1'b1;
        end
        6'h1D: begin
          strobes = viaReg(SRCA_FIELD, ALU_NONE);
          strobes.linkSel = 1'b1;
          strobes.dstSel  = DST_LINK;
        end
        6'h1E: strobes = rAlu(ALU_XOR, IMM_NONE);
        6'h1F: strobes = rAlu(ALU_MULHSS, IMM_NONE);
        6'h20: strobes = rAlu(ALU_CMPEQ, IMM_NONE);
        6'h24: strobes = rAlu(ALU_DIVU, IMM_NONE);
        6'h25: strobes = rAlu(ALU_DIV, IMM_NONE);
        6'h26: strobes = rAlu(ALU_CTLRD, IMM_SHAMT);
        6'h27: strobes = rAlu(ALU_MUL, IMM_NONE);
        6'h28: strobes = rAlu(ALU_CMPGEU, IMM_NONE);
        6'h2D: strobes = excOf(EXC_TRAP);
        6'h2E: begin
          strobes = rAlu(ALU_CTLWR, IMM_SHAMT);
          strobes.dstSel = DST_NONE;
        end
        6'h30: strobes = rAlu(ALU_CMPLTU, IMM_NONE);
        6'h31: strobes = rAlu(ALU_ADD, IMM_NONE);
        6'h34: strobes = excOf(EXC_BREAK);
        6'h39: strobes = rAlu(ALU_SUB, IMM_NONE);
        6'h3A: strobes = rAlu(ALU_SRA, IMM_SHAMT);
        6'h3B: strobes = rAlu(ALU_SRA, IMM_NONE);
        default: strobes = excOf(EXC_ILLEGAL);
      endcase
    end else begin
      case (grpLow)
        3'd0: begin
          if (grpHigh == 3'd0) begin
            strobes.tgtKind = TGT_JUMP;
            strobes.linkSel = 1'b1;
            strobes.dstSel  = DST_LINK;
          end else if (grpHigh == 3'd7) begin
            strobes = excOf(EXC_UNIMPL);
          end else begin
            strobes = iAlu(cmpAlu(grpHigh), (grpHigh >= 3'd5) ? IMM_ZEXT : IMM_SEXT);
          end
        end
        3'd1: begin
          if (grpHigh == 3'd0) strobes.tgtKind = TGT_JUMP;
          else                 strobes = excOf(EXC_ILLEGAL);
        end
        3'd2: begin
          if (primOp == 6'h32) strobes = excOf(EXC_UNIMPL);
          else                 strobes = excOf(EXC_ILLEGAL);
        end
        3'd3, 3'd5, 3'd7: begin
          if (accSize == 2'd3) begin
            if (grpLow != 3'd3) strobes = excOf(EXC_ILLEGAL);
          end else if (accSize == 2'd2 && grpLow == 3'd3) begin
            strobes = '0;
          end else begin
            strobes.immKind = IMM_SEXT;
            strobes.memSize = accSize;
            strobes.memIo   = primOp[5];
            if (grpLow == 3'd5) begin
              strobes.memWrite = 1'b1;
            end else begin
              strobes.memRead   = 1'b1;
              strobes.memSigned = (grpLow == 3'd7) && (accSize != 2'd2);
              strobes.dstSel    = DST_B;
            end
          end
        end
        3'd4: begin
          case (grpHigh)
            3'd0:    strobes = iAlu(ALU_ADD, IMM_SEXT);
            3'd1:    strobes = iAlu(ALU_AND, IMM_ZEXT);
            3'd2:    strobes = iAlu(ALU_OR,  IMM_ZEXT);
            3'd3:    strobes = iAlu(ALU_XOR, IMM_ZEXT);
            3'd4:    strobes = iAlu(ALU_MUL, IMM_SEXT);
            3'd5:    strobes = iAlu(ALU_AND, IMM_HIGH);
            3'd6:    strobes = iAlu(ALU_OR,  IMM_HIGH);
            default: strobes = iAlu(ALU_XOR, IMM_HIGH);
          endcase
        end
        3'd6: begin
          if (grpHigh == 3'd7) begin
            strobes = excOf(EXC_ILLEGAL);
          end else begin
            strobes.tgtKind = TGT_BRANCH;
            strobes.brCond  = grpHigh;
          end
        end
        default: strobes = excOf(EXC_ILLEGAL);
      endcase
    end
  end

endmodule

// File: rtl/insn_dec_datapath.sv
module insn_dec_datapath
  import insn_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [INSN_W-1:0]    insnWord,
  input  logic [INSN_W-1:0]    pcIn,
  input  ctrlStrobesT          strobes,
  output logic [PRIM_W-1:0]    primOp,
  output logic [PRIM_W-1:0]    extOp,
  output logic                 outValid,
  output logic [ALU_W-1:0]     aluOp,
  output logic                 useImm,
  output logic [INSN_W-1:0]    immValue,
  output logic [REG_IDX_W-1:0] srcA,
  output logic [REG_IDX_W-1:0] srcB,
  output logic [REG_IDX_W-1:0] destReg,
  output logic                 regWrite,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [1:0]           memSize,
  output logic                 memSigned,
  output logic                 memIo,
  output logic                 isBranch,
  output logic [COND_W-1:0]    brCond,
  output logic                 isJump,
  output logic                 isJumpReg,
  output logic                 linkSel,
  output logic [INSN_W-1:0]    linkValue,
  output logic [INSN_W-1:0]    target,
  output logic                 excValid,
  output logic [1:0]           excCause
);

  localparam int PAD16 = INSN_W - IMM16_W;
  localparam int PADSH = INSN_W - SH_W;

  logic [REG_IDX_W-1:0] regA, regB, regC;
  logic [SH_W-1:0]      shAmt;
  logic [IMM16_W-1:0]   imm16;
  logic [IMM26_W-1:0]   imm26;
  logic [INSN_W-1:0]    immNext, pcPlus4, brOffset, tgtNext;
  logic [REG_IDX_W-1:0] destNext, srcANext;
  logic                 wrNext;

  assign primOp = insnWord[PRIM_W-1:0];
  assign extOp  = insnWord[EXT_LSB +: PRIM_W];
  assign regA   = insnWord[RA_LSB +: REG_IDX_W];
  assign regB   = insnWord[RB_LSB +: REG_IDX_W];
  assign regC   = insnWord[RC_LSB +: REG_IDX_W];
  assign shAmt  = insnWord[SH_LSB +: SH_W];
  assign imm16  = insnWord[IMM16_LSB +: IMM16_W];
  assign imm26  = insnWord[INSN_W-1 -: IMM26_W];

  always_comb begin
    case (strobes.immKind)
      IMM_SEXT:  immNext = {{PAD16{imm16[IMM16_W-1]}}, imm16};
      IMM_ZEXT:  immNext = {{PAD16{1'b0}}, imm16};
      IMM_HIGH:  immNext = {imm16, {PAD16{1'b0}}};
      IMM_SHAMT: immNext = {{PADSH{1'b0}}, shAmt};
      default:   immNext = '0;
    endcase
  end

  assign pcPlus4  = pcIn + INSN_W'(4);
  assign brOffset = {{PAD16{imm16[IMM16_W-1]}}, imm16[IMM16_W-1:2], 2'b00};

  always_comb begin
    case (strobes.tgtKind)
      TGT_JUMP:   tgtNext = {pcIn[INSN_W-1 -: REGION_W], imm26, 2'b00};
      TGT_BRANCH: tgtNext = pcPlus4 + brOffset;
      default:    tgtNext = '0;
    endcase
  end

  always_comb begin
    case (strobes.dstSel)
      DST_B:    destNext = regB;
      DST_C:    destNext = regC;
      DST_LINK: destNext = LINK_REG;
      default:  destNext = '0;
    endcase
  end

  always_comb begin
    case (strobes.srcASel)
      SRCA_EXC: srcANext = EXC_RET_REG;
      SRCA_BRK: srcANext = BRK_RET_REG;
      SRCA_RET: srcANext = LINK_REG;
      default:  srcANext = regA;
    endcase
  end

  assign wrNext = (strobes.dstSel != DST_NONE) && (destNext != '0) && !strobes.excValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      aluOp     <= '0;
      useImm    <= 1'b0;
      immValue  <= '0;
      srcA      <= '0;
      srcB      <= '0;
      destReg   <= '0;
      regWrite  <= 1'b0;
      memRead   <= 1'b0;
      memWrite  <= 1'b0;
      memSize   <= '0;
      memSigned <= 1'b0;
      memIo     <= 1'b0;
      isBranch  <= 1'b0;
      brCond    <= '0;
      isJump    <= 1'b0;
      isJumpReg <= 1'b0;
      linkSel   <= 1'b0;
      linkValue <= '0;
      target    <= '0;
      excValid  <= 1'b0;
      excCause  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        aluOp     <= strobes.aluOp;
        useImm    <= strobes.immKind != IMM_NONE;
        immValue  <= immNext;
        srcA      <= srcANext;
        srcB      <= regB;
        destReg   <= destNext;
        regWrite  <= wrNext;
        memRead   <= strobes.memRead;
        memWrite  <= strobes.memWrite;
        memSize   <= strobes.memSize;
        memSigned <= strobes.memSigned;
        memIo     <= strobes.memIo;
        isBranch  <= strobes.tgtKind == TGT_BRANCH;
        brCond    <= strobes.brCond;
        isJump    <= strobes.tgtKind == TGT_JUMP;
        isJumpReg <= strobes.jumpReg;
        linkSel   <= strobes.linkSel;
        linkValue <= pcPlus4;
        target    <= tgtNext;
        excValid  <= strobes.excValid;
        excCause  <= strobes.excCause;
      end
    end
  end

  // R2: a cycle without valid input leaves the captured decode untouched
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> ($stable(target) && $stable(aluOp) && $stable(destReg) && $stable(immValue)));

  // R9: no write strobe ever names register zero
  p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> destReg != '0);

  // R8: an access is either a load or a store
  p_mem_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  // R10: exception requests carry no side effects
  p_exc_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !(regWrite || memRead || memWrite || isBranch || isJump || isJumpReg));

  // R6: direct jump keeps the region bits of the captured fetch address
  p_jump_region_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && isJump) |-> target[INSN_W-1 -: REGION_W] == $past(pcIn[INSN_W-1 -: REGION_W]));

  // R7: branch offsets are word aligned, so the target shares the address low bits
  p_br_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && isBranch) |-> target[1:0] == $past(pcIn[1:0]));

  // R13: the link value is the captured fetch address plus one word
  p_link_r13: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && linkSel) |-> linkValue == $past(pcIn) + INSN_W'(4));

endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import insn_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [INSN_W-1:0]    insnWord,
  input  logic [INSN_W-1:0]    pcIn,
  output logic                 outValid,
  output logic [ALU_W-1:0]     aluOp,
  output logic                 useImm,
  output logic [INSN_W-1:0]    immValue,
  output logic [REG_IDX_W-1:0] srcA,
  output logic [REG_IDX_W-1:0] srcB,
  output logic [REG_IDX_W-1:0] destReg,
  output logic                 regWrite,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [1:0]           memSize,
  output logic                 memSigned,
  output logic                 memIo,
  output logic                 isBranch,
  output logic [COND_W-1:0]    brCond,
  output logic                 isJump,
  output logic                 isJumpReg,
  output logic                 linkSel,
  output logic [INSN_W-1:0]    linkValue,
  output logic [INSN_W-1:0]    target,
  output logic                 excValid,
  output logic [1:0]           excCause
);

  logic [PRIM_W-1:0] primOp;
  logic [PRIM_W-1:0] extOp;
  ctrlStrobesT       strobes;

  insn_dec_ctrl ctrl_i (
    .primOp  (primOp),
    .extOp   (extOp),
    .strobes (strobes)
  );

  insn_dec_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .insnWord  (insnWord),
    .pcIn      (pcIn),
    .strobes   (strobes),
    .primOp    (primOp),
    .extOp     (extOp),
    .outValid  (outValid),
    .aluOp     (aluOp),
    .useImm    (useImm),
    .immValue  (immValue),
    .srcA      (srcA),
    .srcB      (srcB),
    .destReg   (destReg),
    .regWrite  (regWrite),
    .memRead   (memRead),
    .memWrite  (memWrite),
    .memSize   (memSize),
    .memSigned (memSigned),
    .memIo     (memIo),
    .isBranch  (isBranch),
    .brCond    (brCond),
    .isJump    (isJump),
    .isJumpReg (isJumpReg),
    .linkSel   (linkSel),
    .linkValue (linkValue),
    .target    (target),
    .excValid  (excValid),
    .excCause  (excCause)
  );

endmodule

// File: tb/insn_field_decoder_tb_top.sv
module insn_field_decoder_tb_top;
  import insn_dec_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] insnWord = '0;
  logic [31:0] pcIn = '0;

  logic        outValid, useImm, regWrite, memRead, memWrite, memSigned, memIo;
  logic        isBranch, isJump, isJumpReg, linkSel, excValid;
  logic [4:0]  aluOp, srcA, srcB, destReg;
  logic [31:0] immValue, linkValue, target;
  logic [1:0]  memSize, excCause;
  logic [2:0]  brCond;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  insn_field_decoder dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insnWord(insnWord), .pcIn(pcIn),
    .outValid(outValid), .aluOp(aluOp), .useImm(useImm), .immValue(immValue),
    .srcA(srcA), .srcB(srcB), .destReg(destReg), .regWrite(regWrite),
    .memRead(memRead), .memWrite(memWrite), .memSize(memSize), .memSigned(memSigned),
    .memIo(memIo), .isBranch(isBranch), .brCond(brCond), .isJump(isJump),
    .isJumpReg(isJumpReg), .linkSel(linkSel), .linkValue(linkValue), .target(target),
    .excValid(excValid), .excCause(excCause)
  );

  // expected-value state
  aluOpE       eAlu;
  logic        eUseImm, eRd, eWrM, eSigned, eIo, eBr, eJmp, eJmpReg, eLink, eExc, eWCand;
  logic [31:0] eImm, eTgt;
  logic [4:0]  eSrcA, eDIdx;
  logic [1:0]  eSize, eCause;
  logic [2:0]  eCond;
  logic [4:0]  curB, curC;
  logic [31:0] curSe, curSh, curPc;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (word %h pc %h)", tag, what, got, exp, insnWord, pcIn);
    end
  endtask

  task automatic rOp(input aluOpE op);
    eAlu = op; eDIdx = curC; eWCand = 1'b1;
  endtask
  task automatic rSh(input aluOpE op);
    rOp(op); eUseImm = 1'b1; eImm = curSh;
  endtask
  task automatic iOp(input aluOpE op, input logic [31:0] imm);
    eAlu = op; eUseImm = 1'b1; eImm = imm; eDIdx = curB; eWCand = 1'b1;
  endtask
  task automatic ld(input logic [1:0] sz, input logic sg, input logic io);
    eRd = 1'b1; eSize = sz; eSigned = sg; eIo = io; eDIdx = curB; eWCand = 1'b1;
    eUseImm = 1'b1; eImm = curSe;
  endtask
  task automatic st(input logic [1:0] sz, input logic io);
    eWrM = 1'b1; eSize = sz; eIo = io; eUseImm = 1'b1; eImm = curSe;
  endtask
  task automatic brc(input logic [2:0] cnd);
    eBr = 1'b1; eCond = cnd; eTgt = curPc + 32'd4 + (curSe & ~32'd3);
  endtask
  task automatic ex(input logic [1:0] cause);
    eExc = 1'b1; eCause = cause;
  endtask
  task automatic viaReg(input logic [4:0] src);
    eJmpReg = 1'b1; eSrcA = src;
  endtask

  task automatic model(input logic [31:0] w, input logic [31:0] pc);
    logic [5:0]  p = w[5:0];
    logic [5:0]  x = w[16:11];
    logic [31:0] ze = {16'h0, w[21:6]};
    logic [31:0] hi = {w[21:6], 16'h0};
    eAlu = ALU_NONE; eUseImm = 0; eRd = 0; eWrM = 0; eSigned = 0; eIo = 0;
    eBr = 0; eJmp = 0; eJmpReg = 0; eLink = 0; eExc = 0; eWCand = 0;
    eImm = 0; eTgt = 0; eSize = 0; eCause = 0; eCond = 0; eDIdx = 0;
    eSrcA = w[31:27]; curB = w[26:22]; curC = w[21:17];
    curSe = {{16{w[21]}}, w[21:6]}; curSh = {27'h0, w[10:6]}; curPc = pc;
    if (p == 6'h3A) begin
      case (x)
        6'h01: begin viaReg(5'd29); eAlu = ALU_EXCRET; end
        6'h02: rSh(ALU_ROL);
        6'h03: rOp(ALU_ROL);
        6'h05: viaReg(5'd31);
        6'h06: rOp(ALU_NOR);
        6'h07: rOp(ALU_MULHUU);
        6'h08: rOp(ALU_CMPGE);
        6'h09: begin viaReg(5'd30); eAlu = ALU_EXCRET; end
        6'h0B: rOp(ALU_ROR);
        6'h0D: viaReg(w[31:27]);
        6'h0E: rOp(ALU_AND);
        6'h10: rOp(ALU_CMPLT);
        6'h12: rSh(ALU_SLL);
        6'h13: rOp(ALU_SLL);
        6'h14: ex(2'd3);
        6'h16: rOp(ALU_OR);
        6'h17: rOp(ALU_MULHSU);
        6'h18: rOp(ALU_CMPNE);
        6'h1A: rSh(ALU_SRL);
        6'h1B: rOp(ALU_SRL);
        6'h1C: begin eLink = 1; eDIdx = curC; eWCand = 1; end
        6'h1D: begin viaReg(w[31:27]); eLink = 1; eDIdx = 5'd31; eWCand = 1; end
        6'h1E: rOp(ALU_XOR);
        6'h1F: rOp(ALU_MULHSS);
        6'h20: rOp(ALU_CMPEQ);
        6'h24: rOp(ALU_DIVU);
        6'h25: rOp(ALU_DIV);
        6'h26: rSh(ALU_CTLRD);
        6'h27: rOp(ALU_MUL);
        6'h28: rOp(ALU_CMPGEU);
        6'h2D: ex(2'd1);
        6'h2E: begin eAlu = ALU_CTLWR; eUseImm = 1; eImm = curSh; end
        6'h30: rOp(ALU_CMPLTU);
        6'h31: rOp(ALU_ADD);
        6'h34: ex(2'd2);
        6'h39: rOp(ALU_SUB);
        6'h3A: rSh(ALU_SRA);
        6'h3B: rOp(ALU_SRA);
        6'h04, 6'h0C, 6'h29, 6'h36: ;
        default: ex(2'd0);
      endcase
    end else begin
      case (p)
        6'h00: begin eJmp = 1; eLink = 1; eDIdx = 5'd31; eWCand = 1; eTgt = {pc[31:28], w[31:6], 2'b00}; end
        6'h01: begin eJmp = 1; eTgt = {pc[31:28], w[31:6], 2'b00}; end
        6'h03: ld(0, 0, 0);   6'h23: ld(0, 0, 1);
        6'h07: ld(0, 1, 0);   6'h27: ld(0, 1, 1);
        6'h0B: ld(1, 0, 0);   6'h2B: ld(1, 0, 1);
        6'h0F: ld(1, 1, 0);   6'h2F: ld(1, 1, 1);
        6'h17: ld(2, 0, 0);   6'h37: ld(2, 0, 1);
        6'h05: st(0, 0);      6'h25: st(0, 1);
        6'h0D: st(1, 0);      6'h2D: st(1, 1);
        6'h15: st(2, 0);      6'h35: st(2, 1);
        6'h04: iOp(ALU_ADD, curSe);
        6'h0C: iOp(ALU_AND, ze);
        6'h14: iOp(ALU_OR, ze);
        6'h1C: iOp(ALU_XOR, ze);
        6'h24: iOp(ALU_MUL, curSe);
        6'h2C: iOp(ALU_AND, hi);
        6'h34: iOp(ALU_OR, hi);
        6'h3C: iOp(ALU_XOR, hi);
        6'h08: iOp(ALU_CMPGE, curSe);
        6'h10: iOp(ALU_CMPLT, curSe);
        6'h18: iOp(ALU_CMPNE, curSe);
        6'h20: iOp(ALU_CMPEQ, curSe);
        6'h28: iOp(ALU_CMPGEU, ze);
        6'h30: iOp(ALU_CMPLTU, ze);
        6'h06: brc(3'd0); 6'h0E: brc(3'd1); 6'h16: brc(3'd2);
        6'h1E: brc(3'd3); 6'h26: brc(3'd4); 6'h2E: brc(3'd5); 6'h36: brc(3'd6);
        6'h32, 6'h38: ex(2'd3);
        6'h13, 6'h1B, 6'h33, 6'h3B: ;
        default: ex(2'd0);
      endcase
    end
  endtask

  task automatic decodeAndCheck(input logic [31:0] w, input logic [31:0] pc, input string tag);
    logic eWr;
    @(negedge clk);
    insnWord = w; pcIn = pc; inValid = 1'b1;
    model(w, pc);
    eWr = eWCand && (eDIdx != 5'd0);
    @(negedge clk);
    inValid = 1'b0;
    chk({tag, " R2"}, "outValid", 32'(outValid), 32'd1);
    chk({tag, " R3"}, "srcB", 32'(srcB), 32'(w[26:22]));
    chk({tag, " R3 R13"}, "srcA", 32'(srcA), 32'(eSrcA));
    chk({tag, " R10 R11"}, "exc", {30'(excValid), excCause}, {30'(eExc), eCause});
    chk({tag, " R9"}, "regWrite", 32'(regWrite), 32'(eWr));
    if (eWr) chk({tag, " R4"}, "destReg", 32'(destReg), 32'(eDIdx));
    chk({tag, " R8"}, "mem", {26'(memRead), memWrite, memSize, memSigned, memIo},
                             {26'(eRd), eWrM, eSize, eSigned, eIo});
    chk({tag, " R7"}, "branch", {28'(isBranch), brCond}, {28'(eBr), eCond});
    chk({tag, " R6 R13"}, "jumps", {29'(isJump), isJumpReg, linkSel}, {29'(eJmp), eJmpReg, eLink});
    if (eBr || eJmp) chk({tag, " R6 R7"}, "target", target, eTgt);
    if (eLink) chk({tag, " R13"}, "linkValue", linkValue, pc + 32'd4);
    chk({tag, " R4 R12"}, "aluOp", 32'(aluOp), 32'(eAlu));
    chk({tag, " R5"}, "useImm", 32'(useImm), 32'(eUseImm));
    if (eUseImm) chk({tag, " R5"}, "immValue", immValue, eImm);
  endtask

  function automatic logic [31:0] mkI(input logic [5:0] op, input logic [4:0] a, input logic [4:0] b, input logic [15:0] imm);
    return {a, b, imm, op};
  endfunction
  function automatic logic [31:0] mkR(input logic [5:0] x, input logic [4:0] a, input logic [4:0] b, input logic [4:0] c, input logic [4:0] sh);
    return {a, b, c, x, sh, 6'h3A};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w, prevTgt, prevImm;
    logic [4:0]  prevAlu, prevDst;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset strobes", {24'(outValid), regWrite, memRead, memWrite, isBranch, isJump, isJumpReg, excValid},
        32'd0);
    inValid = 1'b1; insnWord = 32'h0000_0004;
    @(negedge clk);
    chk("R1", "outValid in reset", 32'(outValid), 32'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "after release", {25'(outValid), regWrite, memRead, memWrite, isBranch, isJump, excValid}, 32'd0);

    // directed corners
    decodeAndCheck(mkI(6'h04, 5'd3, 5'd0, 16'h1234), 32'h100, "R9 addi-r0");
    decodeAndCheck(mkI(6'h17, 5'd3, 5'd0, 16'hFFF0), 32'h100, "R9 load-r0");
    decodeAndCheck(mkI(6'h0F, 5'd2, 5'd7, 16'h8000), 32'h200, "R8 ldh");
    decodeAndCheck(mkI(6'h2F, 5'd2, 5'd7, 16'h0002), 32'h200, "R8 ldhio");
    decodeAndCheck({26'h3FF_FFFF, 6'h00}, 32'hA000_1000, "R6 call");
    decodeAndCheck({26'h000_0001, 6'h01}, 32'hF123_4560, "R6 jmpi");
    decodeAndCheck(mkI(6'h26, 5'd1, 5'd2, 16'hFFFB), 32'h0000_1002, "R7 beq-neg");
    decodeAndCheck(mkI(6'h06, 5'd0, 5'd0, 16'h7FFF), 32'h0000_0000, "R7 br");
    decodeAndCheck(mkI(6'h3E, 5'd1, 5'd2, 16'h0010), 32'h40, "R10 op3E");
    decodeAndCheck(mkI(6'h3F, 5'd1, 5'd2, 16'h0010), 32'h40, "R10 op3F");
    decodeAndCheck(mkR(6'h00, 5'd1, 5'd2, 5'd3, 5'd0), 32'h40, "R10 ext00");
    decodeAndCheck(mkR(6'h2D, 5'd1, 5'd2, 5'd3, 5'd9), 32'h40, "R11 trap");
    decodeAndCheck(mkR(6'h34, 5'd1, 5'd2, 5'd3, 5'd0), 32'h40, "R11 break");
    decodeAndCheck(mkI(6'h32, 5'd1, 5'd2, 16'h0), 32'h40, "R11 custom");
    decodeAndCheck(mkI(6'h38, 5'd1, 5'd2, 16'h0), 32'h40, "R11 op38");
    decodeAndCheck(mkR(6'h14, 5'd1, 5'd2, 5'd3, 5'd0), 32'h40, "R11 ext14");
    decodeAndCheck(mkI(6'h1B, 5'd1, 5'd2, 16'h0), 32'h40, "R12 flush");
    decodeAndCheck(mkR(6'h29, 5'd1, 5'd2, 5'd3, 5'd0), 32'h40, "R12 ext29");
    decodeAndCheck(mkR(6'h05, 5'd4, 5'd2, 5'd3, 5'd0), 32'h40, "R13 ret");
    decodeAndCheck(mkR(6'h01, 5'd4, 5'd2, 5'd3, 5'd0), 32'h40, "R13 eret");
    decodeAndCheck(mkR(6'h1D, 5'd6, 5'd2, 5'd3, 5'd0), 32'h80, "R13 callr");
    decodeAndCheck(mkR(6'h1C, 5'd6, 5'd2, 5'd0, 5'd0), 32'h80, "R13 R9 nextpc-r0");
    decodeAndCheck(mkI(6'h34, 5'd6, 5'd2, 16'hABCD), 32'h80, "R5 orhi");
    decodeAndCheck(mkI(6'h30, 5'd6, 5'd2, 16'hABCD), 32'h80, "R5 cmpltui");
    decodeAndCheck(mkR(6'h3A, 5'd6, 5'd2, 5'd8, 5'd31), 32'h80, "R5 srai");

    // R2: hold while inValid is low
    prevTgt = target; prevImm = immValue; prevAlu = aluOp; prevDst = destReg;
    @(negedge clk);
    insnWord = 32'hFFFF_FFFF; pcIn = 32'h1234_5678;
    @(negedge clk);
    chk("R2", "outValid idle", 32'(outValid), 32'd0);
    chk("R2", "hold target/imm", target ^ immValue, prevTgt ^ prevImm);
    chk("R2", "hold alu/dest", {22'(aluOp), destReg}, {22'(prevAlu), prevDst});

    // random sweep: general words, then register-format words
    for (int i = 0; i < 2000; i++) begin
      w = $urandom;
      decodeAndCheck(w, $urandom, "R3 R4 rand");
    end
    for (int i = 0; i < 2000; i++) begin
      w = $urandom;
      w[5:0] = 6'h3A;
      decodeAndCheck(w, $urandom, "R4 R10 rfmt");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule